// File: doc/BRIEF.md
# Standby Wakeup Stabilization Controller

This block parks a clocked subsystem in a low-power standby state and returns it to normal running. While running, a sleep request takes the block into standby only if a software-controlled standby-enable bit is set. In standby the core clock enable is held low. A chosen edge on the non-maskable interrupt pin wakes the block. That pin is first passed through a synchronizer. After the wake edge the block keeps the core clock gated for an oscillator settling period, then releases the clock and issues a one-cycle completion pulse.

The settling period comes from a 3-bit select code. That code is captured when standby is entered. Six codes give power-of-two waits from 8192 to 262144 oscillator cycles. One code gives a 16-cycle wait, meant for an external clock source that needs no settling. The remaining code is reserved. If it is used, the block applies the longest wait and latches an error flag.

The block has three states. ST_RUN is the normal state with the clock enabled. ST_STANDBY is the sleeping state, waiting for the wake edge. ST_SETTLE is the state in which the settling counter runs. The transitions are as follows:
- ENTER goes from ST_RUN to ST_STANDBY when a sleep request arrives with standby enabled.
- WAKE goes from ST_STANDBY to ST_SETTLE on the selected synchronized NMI edge.
- RELEASE goes from ST_SETTLE to ST_RUN when the wait has elapsed.

Top module: `stdby_wake_ctl`

## Requirements
- R1: While reset is asserted and just after it, core_clk_en is 1, and in_standby, settle_done and rsv_code_err are 0.
- R2: From the running state, the block enters standby only when sleep_req and stby_en are both 1 at a clock edge. After that edge, in_standby is 1 and core_clk_en is 0. A sleep_req with stby_en at 0 has no effect.
- R3: In standby, the wake edge is set by edge_pol: 0 selects a falling edge of nmi_pin, and 1 selects a rising edge. An edge of the other direction leaves the block in standby.
- R4: nmi_pin is synchronized through two flops. Suppose nmi_pin changes before clock edge k and the wait is W cycles. Then settle_done is 1 after edge k+W+2, and core_clk_en stays 0 until that edge.
- R5: The wait W is set by the settle_sel code. Codes 0 to 5 give 8192 shifted left by the code value: 8192, 16384, 32768, 65536, 131072 and 262144 cycles. Code 7 gives 16 cycles. The base exponent (13) and the short wait are parameters.
- R6: Code 6 is reserved. It gives the longest wait (262144 cycles) and sets rsv_code_err one cycle after standby entry. The flag then stays at 1 until reset.
- R7: settle_sel is captured at standby entry. Changing it during standby or settling does not change the wait.
- R8: NMI edges while running have no effect. The block stays running with core_clk_en at 1.
- R9: settle_done is high for exactly one cycle. That cycle is the first one with core_clk_en at 1 and in_standby at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request from the core |
| stby_en | input | 1 | Standby-enable bit |
| edge_pol | input | 1 | Wake edge select: 0 falling, 1 rising |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| settle_sel | input | 3 | Settling wait select code |
| core_clk_en | output | 1 | Core clock enable |
| in_standby | output | 1 | High in standby and during settling |
| settle_done | output | 1 | One-cycle pulse when the clock is released |
| rsv_code_err | output | 1 | Sticky flag for a reserved settle code |

## Verification
The bench measures the exact number of cycles from an NMI pin change to settle_done for every code. A counter with an off-by-one error, a missing synchronizer stage or a wrong table entry therefore shows up as a cycle-count mismatch. It drives the wake edge of the wrong polarity first, which catches a design that wakes on any edge. It uses reserved code 6 and checks both the longest wait and that the error flag survives the return to running. It also changes the select code in mid-standby, so a design that does not capture the code at entry would time the wrong wait. A cycle-accurate reference model compares all outputs on every clock, so a stretched done pulse or a spurious wake while running is also caught.

// File: rtl/stdby_pkg.sv
package stdby_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STANDBY = 2'd1,
        ST_SETTLE  = 2'd2
    } pm_state_e;

    localparam logic [2:0] CODE_RESERVED = 3'd6;
    localparam logic [2:0] CODE_SHORT    = 3'd7;
    localparam int         NUM_LONG      = 6;

endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic pol_i,
    output logic edge_o
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // newest synchronized sample vs the one before it
    always_comb begin
        if (pol_i) edge_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
        else       edge_o = ~chain_q[STAGES-1] &  chain_q[STAGES];
    end

endmodule

// File: rtl/settle_wait_cnt.sv
module settle_wait_cnt
    import stdby_pkg::*;
#(
    parameter int BASE_LOG2  = 13,
    parameter int SHORT_WAIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [2:0] code_i,
    input  logic       step_i,
    output logic       zero_o
);
    localparam int CNT_W    = BASE_LOG2 + NUM_LONG - 1;
    localparam int LONG_MAX = BASE_LOG2 + NUM_LONG - 1;

    logic [CNT_W-1:0] cnt_q;

    // wait length minus one, so the settle state lasts exactly the wait
    function automatic logic [CNT_W-1:0] load_value(input logic [2:0] code);
        logic [63:0] len;
        if (code == CODE_SHORT)         len = 64'(SHORT_WAIT);
        else if (code == CODE_RESERVED) len = 64'd1 << LONG_MAX;
        else                            len = 64'd1 << (BASE_LOG2 + int'(code));
        return CNT_W'(len - 64'd1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_value(code_i);
        end else if (step_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/stdby_wake_ctl.sv
module stdby_wake_ctl
    import stdby_pkg::*;
#(
    parameter int BASE_LOG2   = 13,
    parameter int SHORT_WAIT  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       stby_en,
    input  logic       edge_pol,
    input  logic       nmi_pin,
    input  logic [2:0] settle_sel,
    output logic       core_clk_en,
    output logic       in_standby,
    output logic       settle_done,
    output logic       rsv_code_err
);
    pm_state_e  state_q, state_d;
    logic [2:0] sel_q;
    logic       err_q;
    logic       done_q;
    logic       wake_edge;
    logic       cnt_zero;
    logic       enter;
    logic       load;

    nmi_edge_det #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_pin),
        .pol_i  (edge_pol),
        .edge_o (wake_edge)
    );

    settle_wait_cnt #(
        .BASE_LOG2  (BASE_LOG2),
        .SHORT_WAIT (SHORT_WAIT)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .code_i (sel_q),
        .step_i (state_q == ST_SETTLE),
        .zero_o (cnt_zero)
    );

    assign enter = (state_q == ST_RUN) && sleep_req && stby_en;
    assign load  = (state_q == ST_STANDBY) && wake_edge;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (enter)     state_d = ST_STANDBY;  // ENTER
            ST_STANDBY: if (wake_edge) state_d = ST_SETTLE;   // WAKE
            ST_SETTLE:  if (cnt_zero)  state_d = ST_RUN;      // RELEASE
            default:                   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sel_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_SETTLE) && (state_d == ST_RUN);
            if (enter) begin
                sel_q <= settle_sel;
                if (settle_sel == CODE_RESERVED) err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        core_clk_en  = (state_q == ST_RUN);
        in_standby   = (state_q != ST_RUN);
        settle_done  = done_q;
        rsv_code_err = err_q;
    end

endmodule

// File: rtl/stdby_wake_chk.sv
module stdby_wake_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic stby_en,
    input logic core_clk_en,
    input logic in_standby,
    input logic settle_done,
    input logic rsv_code_err
);
    p_gated_in_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_standby |-> !core_clk_en);

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_standby && sleep_req && stby_en) |=> in_standby);

    p_no_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_standby && !(sleep_req && stby_en)) |=> !in_standby);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_code_err |=> rsv_code_err);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        settle_done |=> !settle_done);

    p_done_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        settle_done |-> (core_clk_en && !in_standby && $past(in_standby)));

endmodule

bind stdby_wake_ctl stdby_wake_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .stby_en      (stby_en),
    .core_clk_en  (core_clk_en),
    .in_standby   (in_standby),
    .settle_done  (settle_done),
    .rsv_code_err (rsv_code_err)
);

// File: tb/stdby_wake_ctl_tb.sv
module stdby_wake_ctl_tb;
    localparam int B     = 5;
    localparam int SHORT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       stby_en = 1'b0;
    logic       edge_pol = 1'b0;
    logic       nmi_pin = 1'b1;
    logic [2:0] settle_sel = 3'd0;
    logic       core_clk_en, in_standby, settle_done, rsv_code_err;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;

    always #5 clk = ~clk;

    stdby_wake_ctl #(.BASE_LOG2(B), .SHORT_WAIT(SHORT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_en(stby_en),
        .edge_pol(edge_pol), .nmi_pin(nmi_pin), .settle_sel(settle_sel),
        .core_clk_en(core_clk_en), .in_standby(in_standby),
        .settle_done(settle_done), .rsv_code_err(rsv_code_err));

    function automatic int wait_of(input int code);
        if (code == 7) return SHORT;
        if (code == 6) return 1 << (B + 5);
        return 1 << (B + code);
    endfunction

    // behavioural reference: mode 0 running, 1 sleeping, 2 settling
    int m_mode = 0, m_left = 0, m_code = 0;
    bit m_done = 0, m_err = 0;
    bit smp[$] = '{0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_code = 0; m_done = 0; m_err = 0;
            smp = '{0, 0, 0};
        end else begin
            bit wake;
            wake = edge_pol ? (smp[1] && !smp[2]) : (!smp[1] && smp[2]);
            m_done = 0;
            if (m_mode == 0) begin
                if (sleep_req && stby_en) begin
                    m_mode = 1; m_code = int'(settle_sel);
                    if (settle_sel == 3'd6) m_err = 1;
                end
            end else if (m_mode == 1) begin
                if (wake) begin m_mode = 2; m_left = wait_of(m_code); end
            end else begin
                m_left--;
                if (m_left == 0) begin m_mode = 0; m_done = 1; end
            end
            smp.push_front(nmi_pin);
            void'(smp.pop_back());
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            check(cur_req, "core_clk_en", core_clk_en, m_mode == 0);
            check(cur_req, "in_standby",  in_standby,  m_mode != 0);
            check(cur_req, "settle_done", settle_done, m_done);
            check(cur_req, "rsv_code_err", rsv_code_err, m_err);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter_standby();
        @(negedge clk); sleep_req = 1'b1; stby_en = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    // R4: drive the pin at a negedge, count edges until settle_done is seen
    task automatic wake_timed(input logic lvl, input int w, input string req);
        int n = 0;
        @(negedge clk); nmi_pin = lvl;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!settle_done && n < 5000);
        check(req, "edges to settle_done", n, w + 3);
        check("R4", "clock released with done", core_clk_en, 1);
        @(negedge clk);
        check("R9", "done is one cycle", settle_done, 0);
        check("R9", "clock stays enabled", core_clk_en, 1);
    endtask

    task automatic run_code(input int code, input string req);
        edge_pol = ~nmi_pin;
        settle_sel = 3'(code);
        cur_req = req;
        enter_standby();
        cycles(4);
        wake_timed(~nmi_pin, wait_of(code), req);
        cycles(4);
    endtask

    initial begin
        cycles(3);
        check("R1", "reset clk_en", core_clk_en, 1);
        check("R1", "reset standby", in_standby, 0);
        check("R1", "reset done", settle_done, 0);
        check("R1", "reset err", rsv_code_err, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        cycles(5);

        cur_req = "R2";
        @(negedge clk); sleep_req = 1'b1; stby_en = 1'b0;
        @(negedge clk); sleep_req = 1'b0;
        check("R2", "no entry without enable", in_standby, 0);
        cycles(2);

        cur_req = "R8";
        nmi_pin = 1'b0; cycles(6); nmi_pin = 1'b1; cycles(6);
        check("R8", "NMI while running ignored", in_standby, 0);
        check("R8", "clock still on", core_clk_en, 1);

        cur_req = "R3";
        edge_pol = 1'b1; settle_sel = 3'd0;
        enter_standby();
        check("R2", "standby entered", in_standby, 1);
        check("R2", "clock gated", core_clk_en, 0);
        nmi_pin = 1'b0; cycles(10);
        check("R3", "wrong-polarity edge ignored", in_standby, 1);
        wake_timed(1'b1, wait_of(0), "R5");
        cycles(4);

        run_code(1, "R5");
        run_code(2, "R5");
        run_code(3, "R5");
        run_code(4, "R5");
        run_code(5, "R5");
        run_code(7, "R5");

        cur_req = "R6";
        check("R6", "err clear before reserved", rsv_code_err, 0);
        edge_pol = ~nmi_pin; settle_sel = 3'd6;
        enter_standby();
        check("R6", "err set at entry", rsv_code_err, 1);
        cycles(3);
        wake_timed(~nmi_pin, 1 << (B + 5), "R6");
        cycles(5);
        check("R6", "err sticky after run", rsv_code_err, 1);

        cur_req = "R7";
        edge_pol = ~nmi_pin; settle_sel = 3'd7;
        enter_standby();
        settle_sel = 3'd5; cycles(3);
        wake_timed(~nmi_pin, SHORT, "R7");
        cycles(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule